// File: doc/BRIEF.md
# Deferred Status-Flag Evaluator

This combinational block rebuilds the six arithmetic status flags (overflow, sign, zero, auxiliary carry, carry, parity) from a compact record of the last flag-setting operation. The record holds four words: an operation code, two dependency operands and an auxiliary word. The operation code picks both the operation class and the operand width (8, 16, 32 or 64 bits). A processor model or emulation pipeline stores the record cheaply whenever an operation runs. It computes the flags later, and only when a consumer asks for them.

Each operation class has its own way of placing operands in the record. Adds, subtracts and multiplies keep both source operands. Carry-chained adds and subtracts store the right operand with the old carry folded in by XOR, so the block must undo that fold. Logic, increment, decrement, shift and rotate records keep the result itself, plus a helper value where one is needed. The output is a full data word with only the six flag positions populated. A separate flag reports operation codes outside the defined range.

Top module: `flag_thunk_eval`

## Requirements
- R1: The output word carries flags only at bit positions carry=0, parity=2, auxiliary=4, zero=6, sign=7 and overflow=11; every other bit is zero.
- R2: Code 0 is the copy operation: the output equals the first dependency word masked to the six flag positions.
- R3: Codes 1..4 add the two dependency words at widths 8, 16, 32 and 64 (in that order). Carry is the unsigned carry out, auxiliary is the carry out of bit 3, and overflow is set when both operands share a sign that differs from the result's sign.
- R4: Codes 5..8 subtract the second dependency word from the first at the four widths. Carry is the unsigned borrow, auxiliary is the borrow out of bit 3, and overflow is set when the operand signs differ and the result sign differs from the first operand's sign.
- R5: Codes 9..12 (add with carry) and 13..16 (subtract with borrow) take the right operand as the second dependency word XOR the auxiliary word. The incoming carry is auxiliary bit 0. The flags follow R3/R4 with that carry included.
- R6: Codes 17..20 (logic) treat the first dependency word as the result; carry, overflow and auxiliary are zero.
- R7: Codes 21..24 (increment) and 25..28 (decrement) treat the first word as the result, and carry equals auxiliary bit 0. For increment, overflow is set on a result of only the sign bit and auxiliary on a low nibble of 0. For decrement, overflow is set on the largest positive value and auxiliary on a low nibble of 0xF.
- R8: Codes 29..32 (shift left) and 33..36 (shift right) take the result in the first word and the result shifted one place less in the second. Carry is that second word's top bit (left) or bit 0 (right). Overflow is the XOR of the two words' top bits, and auxiliary is zero.
- R9: Codes 37..40 (rotate left) and 41..44 (rotate right) take the result in the first word. Left: carry = result bit 0 and overflow = top bit XOR bit 0. Right: carry = top bit and overflow = top bit XOR the next bit down. Sign, zero, auxiliary and parity are copied from the same positions of the auxiliary word.
- R10: Codes 45..48 (unsigned multiply) and 49..52 (signed multiply) set carry and overflow together when the upper half of the double-width product is not the zero-extension (unsigned) or sign-extension (signed) of the lower half. Auxiliary is zero, and sign, zero and parity come from the lower half.
- R11: Outside copy and rotate, parity is set when the low 8 result bits hold an even number of ones, sign is the result's top bit at the selected width, and zero is set when the result is zero at that width.
- R12: Codes 53 and above give an all-zero output and raise `op_bad`; every defined code leaves `op_bad` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | OP_W (8) | Recorded operation code: class and width |
| dep_a | input | DATA_W (64) | First dependency word |
| dep_b | input | DATA_W (64) | Second dependency word |
| aux | input | DATA_W (64) | Auxiliary word: old carry or old flags |
| flags_out | output | DATA_W (64) | Rebuilt flags at their fixed positions |
| op_bad | output | 1 | Operation code outside the defined range |

## Verification
The embedded assertions watch the properties that hold for every input. The output has no bits outside the flag mask, copy and out-of-range codes produce their fixed results, rotates keep the four untouched flags, increment and decrement keep the carry, logic clears carry, overflow and auxiliary, and multiply keeps carry equal to overflow. The exact arithmetic flags can only be shown by the bench sweep. That sweep covers carry and borrow at each width, the signed-overflow boundaries, the carry-in reconstruction, shift and rotate carry sources, and the multiply upper-half tests. The bench compares every code against an independent reference over operand patterns chosen to reach those edges.

// File: rtl/flag_thunk_pkg.sv
package flag_thunk_pkg;

   // Output bit positions of the rebuilt flags
   localparam int FLAG_C_POS = 0;
   localparam int FLAG_P_POS = 2;
   localparam int FLAG_A_POS = 4;
   localparam int FLAG_Z_POS = 6;
   localparam int FLAG_S_POS = 7;
   localparam int FLAG_O_POS = 11;

   // Operand widths supported: 8 << index
   localparam int NUM_SIZES  = 4;
   localparam int MIN_WIDTH  = 8;
   localparam int MAX_WIDTH  = MIN_WIDTH << (NUM_SIZES - 1);

   // Order of the non-copy kinds follows the code grouping
   typedef enum logic [3:0] {
      K_COPY, K_ADD, K_SUB, K_ADC, K_SBB, K_LOGIC, K_INC, K_DEC,
      K_SHL, K_SHR, K_ROL, K_ROR, K_UMUL, K_SMUL
   } op_kind_e;

   localparam int NUM_KINDS  = 14;
   localparam int LAST_CODE  = NUM_SIZES * (NUM_KINDS - 1);

   typedef struct packed {
      logic o;
      logic s;
      logic z;
      logic a;
      logic c;
      logic p;
   } flag_set_t;

   function automatic logic even_ones8(input logic [7:0] v);
      return ~^v;
   endfunction

endpackage

// File: rtl/flag_thunk_decode.sv
module flag_thunk_decode
   import flag_thunk_pkg::*;
#(
   parameter int OP_W = 8
) (
   input  logic [OP_W-1:0] op_code,
   output op_kind_e        kind,
   output logic [1:0]      size_sel,
   output logic            op_bad
);

   localparam logic [OP_W-1:0] LAST = OP_W'(LAST_CODE);

   logic [OP_W-1:0] off;
   logic [3:0]      kind_idx;

   assign off      = op_code - OP_W'(1);
   assign kind_idx = 4'(off >> 2) + 4'd1;

   always_comb begin
      op_bad   = (op_code > LAST);
      kind     = K_COPY;
      size_sel = 2'd0;
      if (op_code != '0 && !op_bad) begin
         kind     = op_kind_e'(kind_idx);
         size_sel = off[1:0];
      end
   end

   // R12: a defined code never decodes as bad, and copy only for code 0
   always_comb begin
      if (op_code <= LAST)
         p_defined_not_bad_r12: assert (!op_bad);
      if (op_code != '0 && op_code <= LAST)
         p_nonzero_not_copy_r2: assert (kind != K_COPY);
   end

endmodule

// File: rtl/flag_thunk_lane.sv
module flag_thunk_lane
   import flag_thunk_pkg::*;
#(
   parameter int W = 8
) (
   input  op_kind_e       kind,
   input  logic [W-1:0]   dep_a,
   input  logic [W-1:0]   dep_b,
   input  logic [W-1:0]   aux,
   output flag_set_t      flags
);

   localparam int HW = 2 * W;

   logic             carry_kind;
   logic             cin;
   logic [W-1:0]     rhs;
   logic [W:0]       sum_w;
   logic [W:0]       diff_w;
   logic [HW-1:0]    uprod;
   logic signed [HW-1:0] sprod;
   logic [W-1:0]     res;
   logic             keep_old;

   assign carry_kind = (kind == K_ADC) || (kind == K_SBB);
   assign cin        = carry_kind ? aux[0] : 1'b0;
   // Undo the carry fold for the carry-chained kinds
   assign rhs        = carry_kind ? (dep_b ^ aux) : dep_b;
   assign sum_w      = {1'b0, dep_a} + {1'b0, rhs} + {{W{1'b0}}, cin};
   assign diff_w     = {1'b0, dep_a} - {1'b0, rhs} - {{W{1'b0}}, cin};
   assign uprod      = {{W{1'b0}}, dep_a} * {{W{1'b0}}, dep_b};
   assign sprod      = $signed({{W{dep_a[W-1]}}, dep_a}) * $signed({{W{dep_b[W-1]}}, dep_b});

   always_comb begin
      flags    = '0;
      res      = dep_a;
      keep_old = 1'b0;
      unique case (kind)
         K_ADD, K_ADC: begin
            res     = sum_w[W-1:0];
            flags.c = sum_w[W];
            flags.a = (dep_a[4] ^ rhs[4] ^ res[4]);
            flags.o = ~(dep_a[W-1] ^ rhs[W-1]) & (dep_a[W-1] ^ res[W-1]);
         end
         K_SUB, K_SBB: begin
            res     = diff_w[W-1:0];
            flags.c = diff_w[W];
            flags.a = (dep_a[4] ^ rhs[4] ^ res[4]);
            flags.o = (dep_a[W-1] ^ rhs[W-1]) & (dep_a[W-1] ^ res[W-1]);
         end
         K_LOGIC: res = dep_a;
         K_INC: begin
            flags.c = aux[0];
            flags.a = (dep_a[3:0] == 4'h0);
            flags.o = (dep_a == {1'b1, {(W-1){1'b0}}});
         end
         K_DEC: begin
            flags.c = aux[0];
            flags.a = (dep_a[3:0] == 4'hF);
            flags.o = (dep_a == {1'b0, {(W-1){1'b1}}});
         end
         K_SHL: begin
            flags.c = dep_b[W-1];
            flags.o = dep_a[W-1] ^ dep_b[W-1];
         end
         K_SHR: begin
            flags.c = dep_b[0];
            flags.o = dep_a[W-1] ^ dep_b[W-1];
         end
         K_ROL: begin
            keep_old = 1'b1;
            flags.c  = dep_a[0];
            flags.o  = dep_a[W-1] ^ dep_a[0];
         end
         K_ROR: begin
            keep_old = 1'b1;
            flags.c  = dep_a[W-1];
            flags.o  = dep_a[W-1] ^ dep_a[W-2];
         end
         K_UMUL: begin
            res     = uprod[W-1:0];
            flags.c = (uprod[HW-1:W] != '0);
            flags.o = flags.c;
         end
         K_SMUL: begin
            res     = sprod[W-1:0];
            flags.c = (sprod[HW-1:W] != {W{sprod[W-1]}});
            flags.o = flags.c;
         end
         default: ;
      endcase
      if (keep_old) begin
         flags.s = aux[FLAG_S_POS];
         flags.z = aux[FLAG_Z_POS];
         flags.a = aux[FLAG_A_POS];
         flags.p = aux[FLAG_P_POS];
      end else begin
         flags.s = res[W-1];
         flags.z = (res == '0);
         flags.p = even_ones8(res[7:0]);
      end
   end

endmodule

// File: rtl/flag_thunk_eval.sv
module flag_thunk_eval
   import flag_thunk_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int OP_W   = 8
) (
   input  logic [OP_W-1:0]   op_code,
   input  logic [DATA_W-1:0] dep_a,
   input  logic [DATA_W-1:0] dep_b,
   input  logic [DATA_W-1:0] aux,
   output logic [DATA_W-1:0] flags_out,
   output logic              op_bad
);

   localparam logic [DATA_W-1:0] FLAG_MASK =
        (DATA_W'(1) << FLAG_C_POS) | (DATA_W'(1) << FLAG_P_POS)
      | (DATA_W'(1) << FLAG_A_POS) | (DATA_W'(1) << FLAG_Z_POS)
      | (DATA_W'(1) << FLAG_S_POS) | (DATA_W'(1) << FLAG_O_POS);

   // Elaboration-time parameter checks
   if (DATA_W < MAX_WIDTH) begin : g_bad_data_w
      $error("DATA_W must cover the widest operand size");
   end
   if (OP_W < $clog2(LAST_CODE + 1)) begin : g_bad_op_w
      $error("OP_W too narrow for the defined operation codes");
   end

   op_kind_e   kind;
   logic [1:0] size_sel;
   flag_set_t  lane_flags [NUM_SIZES];
   flag_set_t  pick;

   flag_thunk_decode #(.OP_W(OP_W)) u_decode (
      .op_code  (op_code),
      .kind     (kind),
      .size_sel (size_sel),
      .op_bad   (op_bad)
   );

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
      localparam int LW = MIN_WIDTH << g;
      flag_thunk_lane #(.W(LW)) u_lane (
         .kind  (kind),
         .dep_a (dep_a[LW-1:0]),
         .dep_b (dep_b[LW-1:0]),
         .aux   (aux[LW-1:0]),
         .flags (lane_flags[g])
      );
   end

   assign pick = lane_flags[size_sel];

   always_comb begin
      flags_out = '0;
      if (op_bad) begin
         flags_out = '0;
      end else if (kind == K_COPY) begin
         flags_out = dep_a & FLAG_MASK;
      end else begin
         flags_out[FLAG_C_POS] = pick.c;
         flags_out[FLAG_P_POS] = pick.p;
         flags_out[FLAG_A_POS] = pick.a;
         flags_out[FLAG_Z_POS] = pick.z;
         flags_out[FLAG_S_POS] = pick.s;
         flags_out[FLAG_O_POS] = pick.o;
      end
   end

   always_comb begin
      p_only_flag_bits_r1: assert ((flags_out & ~FLAG_MASK) == '0);
      if (op_bad)
         p_bad_gives_zero_r12: assert (flags_out == '0);
      if (op_code == '0)
         p_copy_passes_r2: assert (flags_out == (dep_a & FLAG_MASK));
      if (kind == K_ROL || kind == K_ROR)
         p_rotate_keeps_r9: assert (flags_out[FLAG_S_POS] == aux[FLAG_S_POS]
                                 && flags_out[FLAG_Z_POS] == aux[FLAG_Z_POS]
                                 && flags_out[FLAG_A_POS] == aux[FLAG_A_POS]
                                 && flags_out[FLAG_P_POS] == aux[FLAG_P_POS]);
      if (kind == K_INC || kind == K_DEC)
         p_incdec_carry_r7: assert (flags_out[FLAG_C_POS] == aux[0]);
      if (kind == K_UMUL || kind == K_SMUL)
         p_mul_co_pair_r10: assert (flags_out[FLAG_C_POS] == flags_out[FLAG_O_POS]);
      if (kind == K_LOGIC)
         p_logic_clear_r6: assert (!flags_out[FLAG_C_POS] && !flags_out[FLAG_O_POS]
                                && !flags_out[FLAG_A_POS]);
   end

endmodule

// File: tb/flag_thunk_eval_bench.sv
module flag_thunk_eval_bench;

   localparam logic [63:0] FMASK = 64'h8D5;

   logic        clk = 1'b0;
   logic [7:0]  op_code = '0;
   logic [63:0] dep_a = '0, dep_b = '0, aux = '0;
   logic [63:0] flags_out;
   logic        op_bad;
   int          checks = 0;
   int          errors = 0;

   always #5 clk = ~clk;

   flag_thunk_eval u_flag_thunk_eval (
      .op_code   (op_code),
      .dep_a     (dep_a),
      .dep_b     (dep_b),
      .aux       (aux),
      .flags_out (flags_out),
      .op_bad    (op_bad)
   );

   function automatic bit top_bit(input logic [63:0] v, input int w);
      return v[w-1];
   endfunction

   function automatic string req_of(input int op);
      if (op == 0)  return "R2";
      if (op > 52)  return "R12";
      case ((op - 1) / 4)
         0: return "R3";
         1: return "R4";
         2, 3: return "R5";
         4: return "R6";
         5, 6: return "R7";
         7, 8: return "R8";
         9, 10: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [63:0] model(input int op, input logic [63:0] da,
                                        input logic [63:0] db, input logic [63:0] ax);
      int cls, w, ones;
      logic [63:0] m, x, y, r, sx, sy, sr;
      logic [127:0] wide;
      logic signed [127:0] ps;
      bit c, o, af, s, z, p, cin, rot;
      logic [63:0] outv;
      if (op == 0) return da & FMASK;
      if (op > 52) return 64'd0;
      cls = (op - 1) / 4;
      w   = 8 << ((op - 1) % 4);
      m   = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      x = da & m; y = db & m; cin = ax[0];
      c = 0; o = 0; af = 0; rot = 0; r = x;
      s = 0; z = 0; p = 0;
      case (cls)
         0, 2: begin
            if (cls == 2) y = (db ^ ax) & m; else cin = 0;
            wide = {64'd0, x} + {64'd0, y} + {127'd0, cin};
            r  = wide[63:0] & m;
            c  = wide[w];
            af = ((x & 15) + (y & 15) + {63'd0, cin}) > 15;
            o  = (top_bit(x, w) == top_bit(y, w)) && (top_bit(r, w) != top_bit(x, w));
         end
         1, 3: begin
            if (cls == 3) y = (db ^ ax) & m; else cin = 0;
            c  = {64'd0, x} < ({64'd0, y} + {127'd0, cin});
            r  = (x - y - {63'd0, cin}) & m;
            af = (x & 15) < ((y & 15) + {63'd0, cin});
            o  = (top_bit(x, w) != top_bit(y, w)) && (top_bit(r, w) != top_bit(x, w));
         end
         4: ;
         5: begin c = ax[0]; af = (x & 15) == 0;  o = (x == (64'd1 << (w - 1))); end
         6: begin c = ax[0]; af = (x & 15) == 15; o = (x == (m >> 1)); end
         7: begin c = top_bit(y, w); o = top_bit(x, w) ^ top_bit(y, w); end
         8: begin c = y[0];         o = top_bit(x, w) ^ top_bit(y, w); end
         9: begin rot = 1; c = x[0]; o = top_bit(x, w) ^ x[0]; end
         10: begin rot = 1; c = top_bit(x, w); o = top_bit(x, w) ^ x[w-2]; end
         11: begin
            wide = {64'd0, x} * {64'd0, y};
            r = wide[63:0] & m;
            c = (wide >> w) != 0; o = c;
         end
         default: begin
            sx = top_bit(x, w) ? (x | ~m) : x;
            sy = top_bit(y, w) ? (y | ~m) : y;
            ps = $signed({{64{sx[63]}}, sx}) * $signed({{64{sy[63]}}, sy});
            r  = ps[63:0] & m;
            sr = top_bit(r, w) ? (r | ~m) : r;
            c  = (ps != $signed({{64{sr[63]}}, sr})); o = c;
         end
      endcase
      if (rot) begin
         s = ax[7]; z = ax[6]; af = ax[4]; p = ax[2];
      end else begin
         ones = 0;
         for (int i = 0; i < 8; i++) ones += int'(r[i]);
         p = (ones % 2) == 0;
         s = top_bit(r, w);
         z = (r == 0);
      end
      outv = '0;
      outv[0] = c; outv[2] = p; outv[4] = af; outv[6] = z; outv[7] = s; outv[11] = o;
      return outv;
   endfunction

   task automatic check(input string req, input int op, input logic [63:0] got,
                        input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s op=%0d actual=%h expected=%h", req, op, got, exp);
      end
   endtask

   task automatic apply(input int op, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] x);
      logic [63:0] exp;
      @(posedge clk); #1;
      op_code = 8'(op); dep_a = a; dep_b = b; aux = x;
      @(negedge clk);
      exp = model(op, a, b, x);
      check(req_of(op), op, flags_out, exp);
      check("R1", op, flags_out & ~FMASK, 64'd0);
      check("R12", op, {63'd0, op_bad}, {63'd0, (op > 52)});
      // R11: parity, sign and zero for the logic class at every width
      if (op >= 17 && op <= 20)
         check("R11", op, flags_out & 64'hC4, exp & 64'hC4);
   endtask

   logic [63:0] pa [12];
   logic [63:0] pb [12];
   logic [63:0] px [12];

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      pa[0]  = 64'h0;                 pb[0]  = 64'h0;                 px[0]  = 64'h0;
      pa[1]  = 64'hFFFFFFFFFFFFFFFF;  pb[1]  = 64'h1;                 px[1]  = 64'h1;
      pa[2]  = 64'h7F7F7F7F7F7F7F7F;  pb[2]  = 64'h0101010101010101;  px[2]  = 64'h0;
      pa[3]  = 64'h8000000000000000;  pb[3]  = 64'h8000000000000000;  px[3]  = 64'h1;
      pa[4]  = 64'h0123456789ABCDEF;  pb[4]  = 64'hFEDCBA9876543210;  px[4]  = 64'h0;
      pa[5]  = 64'h00000000FFFF8000;  pb[5]  = 64'h0000000000007FFF;  px[5]  = 64'h1;
      pa[6]  = 64'hDEADBEEFCAFEF00D;  pb[6]  = 64'h0000000100000003;  px[6]  = 64'h0;
      pa[7]  = 64'h000000000000000F;  pb[7]  = 64'h000000000000000F;  px[7]  = 64'h1;
      pa[8]  = 64'h7FFFFFFFFFFFFFFF;  pb[8]  = 64'hFFFFFFFFFFFFFFFF;  px[8]  = 64'h8D5;
      pa[9]  = 64'h5555555555555555;  pb[9]  = 64'hAAAAAAAAAAAAAAAA;  px[9]  = 64'h44;
      pa[10] = 64'h8000000080008080;  pb[10] = 64'h4000000040004040;  px[10] = 64'h0;
      pa[11] = 64'hFFFFFFFF00000001;  pb[11] = 64'h00000000FFFFFFFF;  px[11] = 64'h1;

      // reset-like idle state: all-zero record gives all-zero flags (R2)
      @(negedge clk);
      check("R2", 0, flags_out, 64'd0);
      check("R12", 0, {63'd0, op_bad}, 64'd0);

      for (int op = 0; op < 64; op++)
         for (int k = 0; k < 12; k++)
            apply(op, pa[k], pb[k], px[k]);
      apply(200, pa[4], pb[4], px[4]);
      apply(255, pa[8], pb[8], px[8]);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule